// File: doc/BRIEF.md
# DMA Coherence Snoop Handler

This block stands between an I/O DMA master and the coherent cache hierarchy plus main memory. Each DMA request addresses one 128-byte aligned line. Before memory is touched, the handler resolves the request against whatever copy of that line a cache may hold. A write that replaces the whole line only needs the cached copies dropped. A write that replaces part of a line has to probe first. A clean copy is dropped. A modified copy is first written back to memory in full and then dropped, and only after that is the DMA bytes' write issued. A read probes the caches. When a modified copy exists, the read data comes from that copy and memory is not read. Otherwise the line is read from memory. A read never changes cache state.

Requests are handled one at a time. The master holds the request fields steady while `req_valid` is high. The handler raises `req_ready` for exactly one cycle, and only once every snoop and memory action for that request has completed. For reads, `rsp_rdata` is valid in that same cycle. The cache side is reached through a snoop command port with a request/acknowledge handshake. Memory is reached through a line-wide request/acknowledge port with byte enables.

Top module: `dma_snoop_handler`

## Requirements
- R1: A write is full-line only when `req_addr` bits [6:0] are zero, `req_len` equals 128 and all 128 bits of `req_be` are set. Any other write, including an aligned write with length 64 or with a single byte enable clear, takes the partial-line path.
- R2: A full-line write issues exactly one snoop invalidate (`snp_cmd`=1) and no query. It then issues one memory write of `req_wdata` with `req_be`. No write-back happens even when the line is modified.
- R3: A partial write first issues a snoop query (`snp_cmd`=0). When the reply `snp_state` is 0 (invalid), a single memory write of `req_wdata` with `req_be` follows.
- R4: A partial write whose query returns `snp_state`=1 (clean) issues a snoop invalidate and then the memory write.
- R5: A partial write whose query returns `snp_state`=2 (modified) writes the queried line back to memory with all byte enables set. It then invalidates the line and only then issues the DMA memory write. The final memory line is the cached data overlaid with the enabled DMA bytes.
- R6: A read whose query returns modified answers with the cached line in `rsp_rdata`. It issues no memory access and no invalidate, so the line stays modified.
- R7: A read whose query returns invalid or clean reads the line from memory (`mem_we`=0) and answers with that data. It issues no invalidate.
- R8: After reset `req_ready`, `snp_req` and `mem_req` are low. `req_ready` rises only after the last action of the request has been acknowledged, lasts one cycle, and no command is pending while it is high.
- R9: A snoop or memory command keeps its request, command and line stable until acknowledged. A snoop command and a memory command are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | DMA request present, held until `req_ready` |
| req_write | input | 1 | 1 = DMA write, 0 = DMA read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_len | input | LEN_W | Length in bytes |
| req_be | input | LINE_BYTES | Byte enables over the line |
| req_wdata | input | LINE_BITS | Write data, line aligned |
| req_ready | output | 1 | One-cycle completion of the request |
| rsp_rdata | output | LINE_BITS | Read data, valid with `req_ready` on reads |
| snp_req | output | 1 | Snoop command pending |
| snp_cmd | output | 1 | 0 = query, 1 = invalidate |
| snp_line | output | LINE_AW | Line index being snooped |
| snp_ack | input | 1 | Snoop command accepted |
| snp_state | input | 2 | Query reply: 0 invalid, 1 clean, 2 modified |
| snp_rdata | input | LINE_BITS | Query reply line data |
| mem_req | output | 1 | Memory command pending |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_line | output | LINE_AW | Line index in memory |
| mem_be | output | LINE_BYTES | Memory write byte enables |
| mem_wdata | output | LINE_BITS | Memory write data |
| mem_ack | input | 1 | Memory command accepted |
| mem_rdata | input | LINE_BITS | Memory read data |

## Verification
Two functions can land in the same cycle. One is the acknowledge of a command, which the bench can raise in the very cycle the command first appears. The other is the handler's decision on the next step, which for a partial write is taken from the query reply carried by that same acknowledge. The bench runs every path with acknowledge latencies of zero to three cycles, including back-to-back query and invalidate on the snoop port. It also issues requests back to back, so a new request is presented in the cycle after `req_ready`. Each acknowledged command is compared, in order, against a queue of expected commands. The bench builds that queue from its own cache and memory model when the request is presented. A command that arrives early, late, reordered or with wrong data shows up as a mismatch, and `req_ready` with commands still expected is counted as a failure.

// File: rtl/dmasnp_pkg.sv
package dmasnp_pkg;

    typedef enum logic {
        SC_QUERY = 1'b0,
        SC_INVAL = 1'b1
    } snp_cmd_e;

    typedef enum logic [1:0] {
        LS_INV   = 2'd0,
        LS_CLEAN = 2'd1,
        LS_DIRTY = 2'd2
    } line_state_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROBE,
        ST_WBACK,
        ST_INVAL,
        ST_MEMRD,
        ST_MEMWR,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic write;
        logic full;
    } req_kind_t;

    // Bit 1 marks a modified copy, bit 0 alone marks a clean one.
    function automatic line_state_e decode_state(input logic [1:0] code);
        if (code[1])      return LS_DIRTY;
        else if (code[0]) return LS_CLEAN;
        else              return LS_INV;
    endfunction

endpackage

// File: rtl/dmasnp_classify.sv
module dmasnp_classify
    import dmasnp_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 128,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LEN_W     = OFF_W + 1,
    localparam int LINE_AW   = ADDR_W - OFF_W
) (
    input  logic                  write,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [LEN_W-1:0]      len,
    input  logic [LINE_BYTES-1:0] be,
    output logic [LINE_AW-1:0]    line,
    output req_kind_t             kind
);
    logic aligned;
    logic whole_len;
    logic all_bytes;

    assign aligned   = (addr[OFF_W-1:0] == '0);
    assign whole_len = (len == LEN_W'(LINE_BYTES));
    assign all_bytes = &be;

    assign line       = addr[ADDR_W-1:OFF_W];
    assign kind.write = write;
    assign kind.full  = aligned && whole_len && all_bytes;
endmodule

// File: rtl/dmasnp_seq.sv
module dmasnp_seq
    import dmasnp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  req_kind_t   kind,
    input  logic        snp_ack,
    input  line_state_e probe_state,
    input  logic        mem_ack,
    output logic        snp_req,
    output snp_cmd_e    snp_cmd,
    output logic        mem_req,
    output logic        mem_we,
    output logic        wb_sel,
    output logic        ld_probe,
    output logic        ld_mem,
    output logic        req_ready
);
    seq_state_e st, st_nx;

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE:  if (req_valid) st_nx = (kind.write && kind.full) ? ST_INVAL : ST_PROBE;
            ST_PROBE: if (snp_ack) begin
                if (!kind.write) begin
                    st_nx = (probe_state == LS_DIRTY) ? ST_DONE : ST_MEMRD;
                end else begin
                    case (probe_state)
                        LS_DIRTY: st_nx = ST_WBACK;
                        LS_CLEAN: st_nx = ST_INVAL;
                        default:  st_nx = ST_MEMWR;
                    endcase
                end
            end
            ST_WBACK: if (mem_ack) st_nx = ST_INVAL;
            ST_INVAL: if (snp_ack) st_nx = ST_MEMWR;
            ST_MEMRD: if (mem_ack) st_nx = ST_DONE;
            ST_MEMWR: if (mem_ack) st_nx = ST_DONE;
            ST_DONE:  st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    assign snp_req   = (st == ST_PROBE) || (st == ST_INVAL);
    assign snp_cmd   = (st == ST_INVAL) ? SC_INVAL : SC_QUERY;
    assign mem_req   = (st == ST_WBACK) || (st == ST_MEMRD) || (st == ST_MEMWR);
    assign mem_we    = (st == ST_WBACK) || (st == ST_MEMWR);
    assign wb_sel    = (st == ST_WBACK);
    assign ld_probe  = (st == ST_PROBE) && snp_ack;
    assign ld_mem    = (st == ST_MEMRD) && mem_ack;
    assign req_ready = (st == ST_DONE);
endmodule

// File: rtl/dmasnp_datapath.sv
module dmasnp_datapath #(
    parameter int LINE_BYTES = 128,
    localparam int LINE_BITS = LINE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ld_probe,
    input  logic [LINE_BITS-1:0]  snp_rdata,
    input  logic                  ld_mem,
    input  logic [LINE_BITS-1:0]  mem_rdata,
    input  logic                  wb_sel,
    input  logic [LINE_BITS-1:0]  req_wdata,
    input  logic [LINE_BYTES-1:0] req_be,
    output logic [LINE_BITS-1:0]  mem_wdata,
    output logic [LINE_BYTES-1:0] mem_be,
    output logic [LINE_BITS-1:0]  rsp_rdata
);
    logic [LINE_BITS-1:0] line_buf;

    // One line register serves both the write-back source and the read reply.
    always_ff @(posedge clk) begin
        if (rst)           line_buf <= '0;
        else if (ld_probe) line_buf <= snp_rdata;
        else if (ld_mem)   line_buf <= mem_rdata;
    end

    assign mem_wdata = wb_sel ? line_buf : req_wdata;
    assign mem_be    = wb_sel ? '1 : req_be;
    assign rsp_rdata = line_buf;
endmodule

// File: rtl/dma_snoop_handler.sv
module dma_snoop_handler
    import dmasnp_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 128,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LEN_W     = OFF_W + 1,
    localparam int LINE_AW   = ADDR_W - OFF_W,
    localparam int LINE_BITS = LINE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [LEN_W-1:0]      req_len,
    input  logic [LINE_BYTES-1:0] req_be,
    input  logic [LINE_BITS-1:0]  req_wdata,
    output logic                  req_ready,
    output logic [LINE_BITS-1:0]  rsp_rdata,
    output logic                  snp_req,
    output logic                  snp_cmd,
    output logic [LINE_AW-1:0]    snp_line,
    input  logic                  snp_ack,
    input  logic [1:0]            snp_state,
    input  logic [LINE_BITS-1:0]  snp_rdata,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [LINE_AW-1:0]    mem_line,
    output logic [LINE_BYTES-1:0] mem_be,
    output logic [LINE_BITS-1:0]  mem_wdata,
    input  logic                  mem_ack,
    input  logic [LINE_BITS-1:0]  mem_rdata
);
    req_kind_t          kind;
    logic [LINE_AW-1:0] line;
    snp_cmd_e           cmd;
    logic               wb_sel;
    logic               ld_probe;
    logic               ld_mem;

    dmasnp_classify #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_cls (
        .write (req_write),
        .addr  (req_addr),
        .len   (req_len),
        .be    (req_be),
        .line  (line),
        .kind  (kind)
    );

    dmasnp_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .kind        (kind),
        .snp_ack     (snp_ack),
        .probe_state (decode_state(snp_state)),
        .mem_ack     (mem_ack),
        .snp_req     (snp_req),
        .snp_cmd     (cmd),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .wb_sel      (wb_sel),
        .ld_probe    (ld_probe),
        .ld_mem      (ld_mem),
        .req_ready   (req_ready)
    );

    dmasnp_datapath #(.LINE_BYTES(LINE_BYTES)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ld_probe  (ld_probe),
        .snp_rdata (snp_rdata),
        .ld_mem    (ld_mem),
        .mem_rdata (mem_rdata),
        .wb_sel    (wb_sel),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .mem_wdata (mem_wdata),
        .mem_be    (mem_be),
        .rsp_rdata (rsp_rdata)
    );

    assign snp_cmd  = cmd;
    assign snp_line = line;
    assign mem_line = line;
endmodule

// File: rtl/dmasnp_checker.sv
module dmasnp_checker #(
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 128,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LEN_W     = OFF_W + 1,
    localparam int LINE_AW   = ADDR_W - OFF_W
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  req_valid,
    input logic                  req_write,
    input logic [ADDR_W-1:0]     req_addr,
    input logic [LEN_W-1:0]      req_len,
    input logic [LINE_BYTES-1:0] req_be,
    input logic                  req_ready,
    input logic                  snp_req,
    input logic                  snp_cmd,
    input logic [LINE_AW-1:0]    snp_line,
    input logic                  snp_ack,
    input logic                  mem_req,
    input logic                  mem_we,
    input logic [LINE_AW-1:0]    mem_line,
    input logic                  mem_ack
);
    logic whole;
    assign whole = (req_addr[OFF_W-1:0] == '0) && (req_len == LEN_W'(LINE_BYTES)) && (&req_be);

    p_ready_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!snp_req && !mem_req));

    p_ready_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> !req_ready);

    p_one_port_r9: assert property (@(posedge clk) disable iff (rst)
        !(snp_req && mem_req));

    p_snp_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (snp_req && !snp_ack) |=> (snp_req && $stable(snp_cmd) && $stable(snp_line)));

    p_mem_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_line)));

    p_read_keeps_cache_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && snp_req) |-> (snp_cmd == 1'b0));

    p_read_no_memwrite_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && mem_req) |-> !mem_we);

    p_full_no_query_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && whole && snp_req) |-> (snp_cmd == 1'b1));
endmodule

bind dma_snoop_handler dmasnp_checker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .req_be    (req_be),
    .req_ready (req_ready),
    .snp_req   (snp_req),
    .snp_cmd   (snp_cmd),
    .snp_line  (snp_line),
    .snp_ack   (snp_ack),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_line  (mem_line),
    .mem_ack   (mem_ack)
);

// File: tb/sim_dma_snoop_handler.sv
`timescale 1ns/1ps
module sim_dma_snoop_handler;
    localparam int AW    = 16;
    localparam int LB    = 128;
    localparam int LBITS = LB * 8;
    localparam int LAW   = AW - 7;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [AW-1:0]    req_addr = '0;
    logic [7:0]       req_len = '0;
    logic [LB-1:0]    req_be = '0;
    logic [LBITS-1:0] req_wdata = '0;
    logic             req_ready;
    logic [LBITS-1:0] rsp_rdata;
    logic             snp_req;
    logic             snp_cmd;
    logic [LAW-1:0]   snp_line;
    logic             snp_ack = 1'b0;
    logic [1:0]       snp_state = '0;
    logic [LBITS-1:0] snp_rdata = '0;
    logic             mem_req;
    logic             mem_we;
    logic [LAW-1:0]   mem_line;
    logic [LB-1:0]    mem_be;
    logic [LBITS-1:0] mem_wdata;
    logic             mem_ack = 1'b0;
    logic [LBITS-1:0] mem_rdata = '0;

    always #10 clk = ~clk;

    dma_snoop_handler #(.ADDR_W(AW), .LINE_BYTES(LB)) u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_len(req_len), .req_be(req_be), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_rdata(rsp_rdata),
        .snp_req(snp_req), .snp_cmd(snp_cmd), .snp_line(snp_line),
        .snp_ack(snp_ack), .snp_state(snp_state), .snp_rdata(snp_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_line(mem_line),
        .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // Behavioural models of the caches and memory
    logic [1:0]       cst [int];
    logic [LBITS-1:0] cdat [int];
    logic [LBITS-1:0] mdat [int];

    typedef struct {
        int            port;   // 0 snoop, 1 memory
        int            op;     // snoop: 0 query 1 inval; memory: 0 read 1 write
        int            line;
        logic [LB-1:0] be;
        logic [LBITS-1:0] data;
        string         tag;
    } exp_t;
    exp_t q[$];

    int nchk = 0;
    int nfail = 0;
    int slat = 0;
    int mlat = 0;
    int scnt = 0;
    int mcnt = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input string act, input string exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %s expected %s", tag, what, act, exp);
        end
    endtask

    function automatic logic [LBITS-1:0] rline();
        logic [LBITS-1:0] r;
        for (int i = 0; i < LBITS/32; i++) r[32*i +: 32] = $urandom;
        return r;
    endfunction

    function automatic logic [LBITS-1:0] mget(input int l);
        return mdat.exists(l) ? mdat[l] : '0;
    endfunction

    function automatic logic [LBITS-1:0] merge(input logic [LBITS-1:0] base,
                                              input logic [LBITS-1:0] nw,
                                              input logic [LB-1:0] be);
        logic [LBITS-1:0] r = base;
        for (int i = 0; i < LB; i++) if (be[i]) r[8*i +: 8] = nw[8*i +: 8];
        return r;
    endfunction

    task automatic push(input int port, input int op, input int line,
                        input logic [LB-1:0] be, input logic [LBITS-1:0] d, input string tag);
        exp_t e;
        e.port = port; e.op = op; e.line = line; e.be = be; e.data = d; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic match(input int port, input int op, input int line,
                         input logic [LB-1:0] be, input logic [LBITS-1:0] d);
        exp_t e;
        bit ok;
        if (q.size() == 0) begin
            chk(1'b0, "R9", "unexpected command",
                $sformatf("port%0d op%0d line%0d", port, op, line), "none");
            return;
        end
        e = q.pop_front();
        ok = (e.port == port) && (e.op == op) && (e.line == line);
        if (ok && port == 1 && op == 1) ok = (e.be == be) && (e.data == d);
        chk(ok, e.tag, "command order/content",
            $sformatf("port%0d op%0d line%0d be%h", port, op, line, be),
            $sformatf("port%0d op%0d line%0d be%h", e.port, e.op, e.line, e.be));
    endtask

    // Responders: acknowledge after a programmable latency, sampled on the falling edge
    always @(negedge clk) begin
        if (snp_ack) begin
            snp_ack = 1'b0;
            scnt = 0;
        end else if (!rst && snp_req) begin
            if (scnt >= slat) begin
                match(0, int'(snp_cmd), int'(snp_line), '0, '0);
                if (snp_cmd == 1'b0) begin
                    snp_state = cst.exists(int'(snp_line)) ? cst[int'(snp_line)] : 2'd0;
                    snp_rdata = cdat.exists(int'(snp_line)) ? cdat[int'(snp_line)] : '0;
                end else begin
                    cst[int'(snp_line)] = 2'd0;
                end
                snp_ack = 1'b1;
            end else scnt++;
        end
        if (mem_ack) begin
            mem_ack = 1'b0;
            mcnt = 0;
        end else if (!rst && mem_req) begin
            if (mcnt >= mlat) begin
                match(1, int'(mem_we), int'(mem_line), mem_be, mem_wdata);
                if (mem_we) mdat[int'(mem_line)] = merge(mget(int'(mem_line)), mem_wdata, mem_be);
                else        mem_rdata = mget(int'(mem_line));
                mem_ack = 1'b1;
            end else mcnt++;
        end
    end

    task automatic do_req(input bit wr, input logic [AW-1:0] addr, input logic [7:0] len,
                          input logic [LB-1:0] be, input logic [LBITS-1:0] wd, input string tag);
        int line;
        int st;
        bit full;
        int cyc;
        logic [LBITS-1:0] exp_rd;
        line = int'(addr >> 7);
        full = (addr[6:0] == 7'd0) && (len == 8'd128) && (&be);
        st = cst.exists(line) ? int'(cst[line]) : 0;
        exp_rd = '0;
        if (wr && full) begin
            push(0, 1, line, '0, '0, tag);
            push(1, 1, line, be, wd, tag);
        end else if (wr) begin
            push(0, 0, line, '0, '0, tag);
            if (st == 2) begin
                push(1, 1, line, '1, cdat[line], tag);
                push(0, 1, line, '0, '0, tag);
            end else if (st == 1) begin
                push(0, 1, line, '0, '0, tag);
            end
            push(1, 1, line, be, wd, tag);
        end else begin
            push(0, 0, line, '0, '0, tag);
            if (st == 2) exp_rd = cdat[line];
            else begin
                push(1, 0, line, '0, '0, tag);
                exp_rd = mget(line);
            end
        end
        req_write = wr; req_addr = addr; req_len = len; req_be = be; req_wdata = wd;
        req_valid = 1'b1;
        cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (req_ready) begin
                chk(q.size() == 0, "R8", "ready with commands still expected",
                    $sformatf("%0d", q.size()), "0");
                if (!wr) chk(rsp_rdata == exp_rd, tag, "read data",
                             $sformatf("%h", rsp_rdata[63:0]), $sformatf("%h", exp_rd[63:0]));
                break;
            end
            if (cyc > 300) begin
                chk(1'b0, tag, "request never completed", "timeout", "ready");
                q.delete();
                break;
            end
        end
        req_valid = 1'b0;
    endtask

    task automatic set_line(input int l, input logic [1:0] s);
        cst[l] = s;
        cdat[l] = rline();
    endtask

    task automatic check_mem(input int l, input logic [LBITS-1:0] e, input string tag);
        chk(mget(l) == e, tag, "memory line",
            $sformatf("%h", mget(l)[63:0]), $sformatf("%h", e[63:0]));
    endtask

    initial begin : main
        logic [LBITS-1:0] d;
        logic [LBITS-1:0] keep;
        logic [LB-1:0]    lo_be;
        lo_be = {{(LB/2){1'b0}}, {(LB/2){1'b1}}};
        repeat (3) @(negedge clk);
        chk(!req_ready && !snp_req && !mem_req, "R8", "reset outputs",
            $sformatf("%b%b%b", req_ready, snp_req, mem_req), "000");
        rst = 1'b0;
        @(negedge clk);

        // R2: full-line write, uncached and then modified target
        d = rline();
        do_req(1, 16'h0080, 8'd128, '1, d, "R2");
        check_mem(1, d, "R2");
        slat = 2; mlat = 1;
        set_line(2, 2'd2);
        d = rline();
        do_req(1, 16'h0100, 8'd128, '1, d, "R2");
        check_mem(2, d, "R2");

        // R3: partial write to an uncached line
        slat = 0; mlat = 0;
        d = rline();
        do_req(1, 16'h0180, 8'd64, lo_be, d, "R3");
        check_mem(3, merge('0, d, lo_be), "R3");

        // R4: partial write to a clean line
        set_line(4, 2'd1);
        mdat[4] = rline(); keep = mdat[4];
        d = rline();
        do_req(1, 16'h0200, 8'd64, lo_be, d, "R4");
        check_mem(4, merge(keep, d, lo_be), "R4");

        // R5: partial write to a modified line, then read back through memory (R7)
        slat = 1; mlat = 2;
        set_line(5, 2'd2); keep = cdat[5];
        d = rline();
        do_req(1, 16'h0290, 8'd32, lo_be, d, "R5");
        check_mem(5, merge(keep, d, lo_be), "R5");
        do_req(0, 16'h0280, 8'd128, '0, '0, "R7");

        // R6: read served from a modified copy, twice, line stays modified
        slat = 0; mlat = 0;
        set_line(6, 2'd2);
        mdat[6] = rline();
        do_req(0, 16'h0300, 8'd128, '0, '0, "R6");
        do_req(0, 16'h0300, 8'd128, '0, '0, "R6");
        chk(cst[6] == 2'd2, "R6", "line state after reads", $sformatf("%0d", cst[6]), "2");

        // R7: clean copy read from memory
        set_line(7, 2'd1);
        mdat[7] = rline();
        do_req(0, 16'h0380, 8'd128, '0, '0, "R7");
        chk(cst[7] == 2'd1, "R7", "line state after read", $sformatf("%0d", cst[7]), "1");

        // R1: near-miss full-line writes take the partial path on a modified line
        set_line(8, 2'd2);
        do_req(1, 16'h0400, 8'd128, {1'b0, {(LB-1){1'b1}}}, rline(), "R1");
        set_line(9, 2'd2);
        do_req(1, 16'h0480, 8'd64, '1, rline(), "R1");
        set_line(10, 2'd2);
        do_req(1, 16'h0504, 8'd128, '1, rline(), "R1");

        // R9: random mix with varied acknowledge latencies, back to back
        for (int k = 0; k < 60; k++) begin
            int l;
            int kind;
            logic [LB-1:0] be;
            l = 16 + int'($urandom_range(0, 5));
            kind = int'($urandom_range(0, 2));
            slat = int'($urandom_range(0, 3));
            mlat = int'($urandom_range(0, 3));
            if ($urandom_range(0, 1) == 1) set_line(l, 2'($urandom_range(0, 2)));
            be = {$urandom, $urandom, $urandom, $urandom};
            case (kind)
                0: do_req(0, AW'(l * 128), 8'd128, '0, '0, "R9");
                1: do_req(1, AW'(l * 128), 8'd128, '1, rline(), "R9");
                default: do_req(1, AW'(l * 128 + 8), 8'd16, be, rline(), "R9");
            endcase
        end

        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    end

    initial begin : watchdog
        #(20 * 150000);
        if (!finished) begin
            finished = 1;
            nchk++;
            nfail++;
            $display("FAIL R8 watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    end
endmodule